// File: doc/BRIEF.md
# Dual-Channel Staged DAC Code Register Bank

This block keeps the digital settings of a two-channel digital-to-analog converter. A serial front end hands it decoded write commands, each naming a target channel and carrying a reference-buffer enable, a two-bit power mode and a 12-bit data field. Every write lands in the staging register of the addressed channel only. A second, active register per channel drives the converter, so a controller can prepare new values while the outputs stay put.

An asynchronous, active-low load strobe moves staged values into the active registers. The strobe first passes through a two-flop synchronizer. The synchronized level then acts as a transparent latch control rather than an edge trigger. While it stays asserted, every write goes straight through to the active register. A single pulse moves both channels at the same moment. A per-channel pending flag records that new data is waiting in the staging register, and an active register is only enabled when there is something new to take. For 10-bit and 8-bit builds, the code is the top bits of the 12-bit field and the low bits are dropped.

Top module: `dacbank_top`

## Requirements
- R1: While reset is asserted, and after it until a write and load occur, every active code is 0, every buffer enable is 0 and every power mode is 00 (normal).
- R2: A write made while the synchronized load is inactive changes no active output.
- R3: Channel select value 0 writes channel A (index 0) and value 1 writes channel B (index 1). The other channel's staged value is left alone.
- R4: load_n passes through two synchronizer flops. After load_n is driven low ahead of clock edge k, the active registers take the staged values at edge k+2, and they are unchanged after edges k and k+1.
- R5: While the synchronized load stays active, a write reaches the active outputs at the same clock edge at which it is staged.
- R6: An active register is enabled only when its channel has a pending write or a write in the current cycle. A load pulse with no write since the last transfer leaves the outputs unchanged.
- R7: A single load pulse moves both channels' staged values to their active registers at the same edge.
- R8: The buffer enable and the power mode (00 normal, 01 1 kOhm pull-down, 10 100 kOhm pull-down, 11 high impedance) are stored with the code and follow the same load rule. The code is kept in every power mode.
- R9: With DATA_W below 12, the active code is wr_data[11 -: DATA_W]. An 8-bit build keeps bits 11 to 4.
- R10: When a write and an active load fall in the same cycle, the new write is what the active register takes, and nothing stays pending afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Decoded write command present this cycle |
| wr_chan | input | SEL_W (1) | Target channel of the write |
| wr_buf_en | input | 1 | Reference buffer enable to store |
| wr_pmode | input | 2 | Power mode to store |
| wr_data | input | FIELD_W (12) | Code field, MSB aligned |
| load_n | input | 1 | Asynchronous active-low load strobe |
| act_code | output | NUM_CH x DATA_W | Active code per channel |
| act_buf_en | output | NUM_CH | Active reference buffer enable per channel |
| act_pmode | output | NUM_CH x 2 | Active power mode per channel |

## Verification
The hardest case to reach from the ports is the timing relation between the asynchronous strobe and a write. A write that arrives while the synchronized load is still active must pass straight through. A write that arrives after the load has dropped must only be staged. This window is shifted two cycles away from the pin. The stimulus holds load_n low, issues writes inside that window, releases load_n and waits out the synchronizer before writing again. It also drives load_n low in a chosen cycle and samples the outputs edge by edge to check the two-cycle latency. A behavioural model that includes its own synchronizer delay queue is compared with every output on every clock, and a second instance built for 8 bits is checked against the same model.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_PD_1K   = 2'b01,
    PM_PD_100K = 2'b10,
    PM_HIZ     = 2'b11
  } pmode_e;

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              wr_hit_i,
  input  logic              wr_buf_i,
  input  pmode_e            wr_mode_i,
  input  logic [DATA_W-1:0] wr_code_i,
  output logic [DATA_W-1:0] act_code_o,
  output logic              act_buf_o,
  output pmode_e            act_mode_o
);

  logic [DATA_W-1:0] stg_code_q, stg_code_d;
  logic              stg_buf_q,  stg_buf_d;
  pmode_e            stg_mode_q, stg_mode_d;
  logic [DATA_W-1:0] act_code_q, act_code_d;
  logic              act_buf_q,  act_buf_d;
  pmode_e            act_mode_q, act_mode_d;
  logic              pend_q, pend_d;
  logic              act_en;

  always_comb begin
    stg_code_d = stg_code_q;
    stg_buf_d  = stg_buf_q;
    stg_mode_d = stg_mode_q;
    if (wr_hit_i) begin
      stg_code_d = wr_code_i;
      stg_buf_d  = wr_buf_i;
      stg_mode_d = wr_mode_i;
    end
    act_en     = load_i && (pend_q || wr_hit_i);
    act_code_d = wr_hit_i ? wr_code_i : stg_code_q;
    act_buf_d  = wr_hit_i ? wr_buf_i  : stg_buf_q;
    act_mode_d = wr_hit_i ? wr_mode_i : stg_mode_q;
    if (load_i)        pend_d = 1'b0;
    else if (wr_hit_i) pend_d = 1'b1;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_code_q <= '0;
      stg_buf_q  <= 1'b0;
      stg_mode_q <= PM_NORMAL;
      pend_q     <= 1'b0;
    end else begin
      stg_code_q <= stg_code_d;
      stg_buf_q  <= stg_buf_d;
      stg_mode_q <= stg_mode_d;
      pend_q     <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code_q <= '0;
      act_buf_q  <= 1'b0;
      act_mode_q <= PM_NORMAL;
    end else if (act_en) begin
      act_code_q <= act_code_d;
      act_buf_q  <= act_buf_d;
      act_mode_q <= act_mode_d;
    end
  end

  assign act_code_o = act_code_q;
  assign act_buf_o  = act_buf_q;
  assign act_mode_o = act_mode_q;

  // R2: without an active load the outputs hold
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(act_code_q) && $stable(act_buf_q) && $stable(act_mode_q)));

  // R6: a load with nothing new enables no flop
  a_r6_no_needless_update: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !pend_q && !wr_hit_i) |=> $stable(act_code_q));

  // R10: same-cycle write and load pass the fresh code
  a_r10_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && wr_hit_i) |=> (act_code_q == $past(wr_code_i)));

  // R10: an active load leaves nothing pending
  a_r10_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !pend_q);

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int FIELD_W = 12,
  parameter int DATA_W  = 12,
  parameter int SYNC_N  = 2,
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  input  logic [SEL_W-1:0]              wr_chan,
  input  logic                          wr_buf_en,
  input  logic [1:0]                    wr_pmode,
  input  logic [FIELD_W-1:0]            wr_data,
  input  logic                          load_n,
  output logic [NUM_CH-1:0][DATA_W-1:0] act_code,
  output logic [NUM_CH-1:0]             act_buf_en,
  output logic [NUM_CH-1:0][1:0]        act_pmode
);

  logic              load_n_s;
  logic              load_act;
  logic [NUM_CH-1:0] hit;
  logic [DATA_W-1:0] code_msb;
  pmode_e            wr_mode;

  dacbank_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_load_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(load_n),
    .sync_o (load_n_s)
  );

  assign load_act = !load_n_s;
  assign code_msb = wr_data[FIELD_W-1 -: DATA_W];
  assign wr_mode  = pmode_e'(wr_pmode);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pmode_e mode_w;
    assign hit[c] = wr_valid && (wr_chan == SEL_W'(c));

    dacbank_chan #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_act),
      .wr_hit_i  (hit[c]),
      .wr_buf_i  (wr_buf_en),
      .wr_mode_i (wr_mode),
      .wr_code_i (code_msb),
      .act_code_o(act_code[c]),
      .act_buf_o (act_buf_en[c]),
      .act_mode_o(mode_w)
    );
    assign act_pmode[c] = mode_w;
  end

  // R3: a write addresses at most one channel
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R4: the synchronized strobe follows the pin with delay
  a_r4_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && $past(!load_n)) |=> !load_n_s);

endmodule

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [0:0]  wr_chan;
  logic        wr_buf_en;
  logic [1:0]  wr_pmode;
  logic [11:0] wr_data;
  logic        load_n;
  logic [1:0][11:0] code12;
  logic [1:0][7:0]  code8;
  logic [1:0]       buf12, buf8;
  logic [1:0][1:0]  mode12, mode8;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dacbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_buf_en(wr_buf_en), .wr_pmode(wr_pmode), .wr_data(wr_data),
    .load_n(load_n), .act_code(code12), .act_buf_en(buf12), .act_pmode(mode12)
  );

  dacbank_top #(.DATA_W(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_buf_en(wr_buf_en), .wr_pmode(wr_pmode), .wr_data(wr_data),
    .load_n(load_n), .act_code(code8), .act_buf_en(buf8), .act_pmode(mode8)
  );

  // behavioural reference model
  int m_stg_code[2], m_stg_buf[2], m_stg_mode[2];
  int m_act_code[2], m_act_buf[2], m_act_mode[2];
  bit m_pend[2];
  int lq[$] = '{1, 1};

  always @(posedge clk) begin
    if (!rst_n) begin
      lq = '{1, 1};
      for (int c = 0; c < 2; c++) begin
        m_stg_code[c] = 0; m_stg_buf[c] = 0; m_stg_mode[c] = 0;
        m_act_code[c] = 0; m_act_buf[c] = 0; m_act_mode[c] = 0;
        m_pend[c] = 0;
      end
    end else begin
      int eff;
      eff = lq.pop_front();
      lq.push_back(int'(load_n));
      for (int c = 0; c < 2; c++) begin
        bit h, ld;
        h  = wr_valid && (int'(wr_chan) == c);
        ld = (eff == 0);
        if (ld && (m_pend[c] || h)) begin
          m_act_code[c] = h ? int'(wr_data)   : m_stg_code[c];
          m_act_buf[c]  = h ? int'(wr_buf_en) : m_stg_buf[c];
          m_act_mode[c] = h ? int'(wr_pmode)  : m_stg_mode[c];
        end
        if (h) begin
          m_stg_code[c] = int'(wr_data);
          m_stg_buf[c]  = int'(wr_buf_en);
          m_stg_mode[c] = int'(wr_pmode);
        end
        m_pend[c] = ld ? 1'b0 : (h ? 1'b1 : m_pend[c]);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison, R9 on the 8-bit build
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        check(phase, int'(code12[c]), m_act_code[c]);
        check(phase, int'(buf12[c]),  m_act_buf[c]);
        check(phase, int'(mode12[c]), m_act_mode[c]);
        check("R9", int'(code8[c]), m_act_code[c] >> 4);
        check("R8", int'(mode8[c]), m_act_mode[c]);
      end
    end
  end

  task automatic wr(input int ch, input int b, input int md, input int d);
    wr_valid  = 1'b1;
    wr_chan   = 1'(ch);
    wr_buf_en = 1'(b);
    wr_pmode  = 2'(md);
    wr_data   = 12'(d);
    @(negedge clk);
    wr_valid  = 1'b0;
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_chan = 1'b0; wr_buf_en = 1'b0;
    wr_pmode = 2'b00; wr_data = '0; load_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(code12), 0);
    check("R1", int'(buf12), 0);
    check("R1", int'(mode12), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", int'(code12), 0);

    // R2 / R3: staged writes do not reach outputs
    phase = "R2";
    wr(0, 1, 1, 'hABC);
    wr(1, 0, 3, 'h123);
    repeat (3) @(negedge clk);
    check("R2", int'(code12[0]), 0);
    check("R2", int'(code12[1]), 0);

    // R7 / R8 / R9: one pulse moves both channels
    phase = "R7";
    pulse_load();
    check("R7", int'(code12[0]), 'hABC);
    check("R7", int'(code12[1]), 'h123);
    check("R8", int'(buf12), 2'b01);
    check("R8", int'(mode12[0]), 1);
    check("R8", int'(mode12[1]), 3);
    check("R9", int'(code8[0]), 'hAB);
    check("R9", int'(code8[1]), 'h12);

    // R3: channel select 1 addresses channel B only
    phase = "R3";
    wr(1, 1, 0, 'hFFF);
    pulse_load();
    check("R3", int'(code12[0]), 'hABC);
    check("R3", int'(code12[1]), 'hFFF);

    // R6: load with nothing pending
    phase = "R6";
    pulse_load();
    check("R6", int'(code12[0]), 'hABC);
    check("R6", int'(code12[1]), 'hFFF);

    // R4: two-flop latency
    phase = "R4";
    wr(0, 0, 2, 'h555);
    load_n = 1'b0;
    @(negedge clk);
    check("R4", int'(code12[0]), 'hABC);
    @(negedge clk);
    check("R4", int'(code12[0]), 'hABC);
    @(negedge clk);
    check("R4", int'(code12[0]), 'h555);
    check("R8", int'(mode12[0]), 2);

    // R5 / R10: transparent while load held
    phase = "R5";
    wr(1, 0, 0, 'h0F0);
    check("R5", int'(code12[1]), 'h0F0);
    phase = "R10";
    wr(0, 1, 3, 'h3C3);
    check("R10", int'(code12[0]), 'h3C3);
    load_n = 1'b1;
    repeat (3) @(negedge clk);
    phase = "R2";
    wr(1, 1, 1, 'h777);
    repeat (2) @(negedge clk);
    check("R2", int'(code12[1]), 'h0F0);

    // R8: code kept through every power mode
    phase = "R8";
    for (int m = 0; m < 4; m++) begin
      wr(0, m & 1, m, 'h900 + m);
      pulse_load();
      check("R8", int'(mode12[0]), m);
      check("R8", int'(code12[0]), 'h900 + m);
    end

    // R1: reset again clears everything
    phase = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'(code12), 0);
    check("R1", int'(mode12), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule